// File: doc/BRIEF.md
# Polarity-Selectable PWM Blanking Modulator

This block drives the single blanking line of a multiplexed vacuum-fluorescent tube driver. Each grid's multiplex slot is split into sixteen equal phases. A 4-bit brightness level decides how many of those phases the tube is enabled. The first phase of every slot is always blanked, so slow drivers have time to switch off and phosphors have time to decay before the next grid lights. As a result the enabled time runs from one sixteenth to fifteen sixteenths of the slot.

The multiplex engine pulses `slot_start_i` at the start of each grid slot. That pulse restarts the phase timer and captures the brightness level, so a level change never cuts a pulse short in the middle of a slot. A force-blank request holds the tube disabled, for example during shutdown or during the first multiplex cycle after the display is reconfigured. A polarity select sets whether a high or a low output level disables the tube.

Top module: `pwm_blank_mod`

## Requirements
- R1: After reset, `blank_o` is 1, and the output stays at the disabling level until the first slot-start pulse is seen.
- R2: A slot-start pulse restarts the slot at phase 0. The phase index advances by one every PHASE_LEN clock cycles (default 4) and saturates at 15 until the next slot start.
- R3: Phase 0 of every slot is blanked whatever the brightness level.
- R4: With a captured level k, the tube is enabled in phases 1 through k and blanked in phases k+1 through 15. When the slot-start pulse is sampled at clock edge E, `blank_o` after edge E+1+j reflects phase min(j / PHASE_LEN, 15).
- R5: A captured level of 0 behaves exactly like a level of 1.
- R6: The level is captured only on the cycle that carries the slot-start pulse. Changes to `level_i` at any other time have no effect until the next slot start.
- R7: While `force_blank_i` is 1 at a clock edge, `blank_o` after that edge is at the disabling level.
- R8: `pol_sel_i` = 0 means a high `blank_o` disables the tube. `pol_sel_i` = 1 means a low `blank_o` disables it. The value sampled at an edge applies to the output after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| level_i | input | IW (4) | Brightness level, captured at slot start |
| pol_sel_i | input | 1 | Output polarity select (0: high blanks) |
| slot_start_i | input | 1 | One-cycle pulse marking the start of a grid slot |
| force_blank_i | input | 1 | Holds the tube disabled while high |
| blank_o | output | 1 | Registered blanking output to the tube driver |

## Verification
Every result arrives through the single output register. A force or polarity input sampled at a clock edge therefore shows on `blank_o` right after that edge. A slot start sampled at edge E has its phase-0 blank appear after edge E+1, and each later phase boundary appears PHASE_LEN cycles after the previous one. The bench updates its reference model at each rising edge from the inputs it drove at the preceding falling edge. It then compares the output at the next falling edge, so every comparison lands exactly one register stage after the stimulus. Random runs use slot periods both shorter and longer than a full sixteen-phase slot, which exercises truncated slots as well as the saturated last phase.

// File: rtl/pwm_blank_pkg.sv
package pwm_blank_pkg;

   typedef enum logic {
      POL_HIGH_BLANKS = 1'b0,
      POL_LOW_BLANKS  = 1'b1
   } pol_e;

   // Map an internal "tube disabled" flag onto the selected pin level.
   function automatic logic drive_level(input logic disabled, input pol_e pol);
      return (pol == POL_HIGH_BLANKS) ? disabled : ~disabled;
   endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
   parameter int IW        = 4,
   parameter int PHASE_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic [IW-1:0] phase_o,
   output logic          live_o
);
   localparam logic [IW-1:0] LAST_PHASE = {IW{1'b1}};

   logic adv;

   generate
      if (PHASE_LEN == 1) begin : g_nodiv
         assign adv = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(PHASE_LEN);
         localparam logic [DW-1:0] DIV_END = DW'(PHASE_LEN - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (start_i)
               div_q <= '0;
            else if (live_o)
               div_q <= (div_q == DIV_END) ? '0 : div_q + 1'b1;
         end

         assign adv = (div_q == DIV_END);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= '0;
         live_o  <= 1'b0;
      end else if (start_i) begin
         phase_o <= '0;
         live_o  <= 1'b1;
      end else if (live_o && adv && (phase_o != LAST_PHASE)) begin
         phase_o <= phase_o + 1'b1;
      end
   end

endmodule

// File: rtl/level_latch.sv
module level_latch #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture_i,
   input  logic [IW-1:0] level_i,
   output logic [IW-1:0] level_o
);
   localparam logic [IW-1:0] MIN_LEVEL = IW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_o <= MIN_LEVEL;
      else if (capture_i)
         level_o <= (level_i == '0) ? MIN_LEVEL : level_i;
   end

endmodule

// File: rtl/blank_shaper.sv
module blank_shaper
   import pwm_blank_pkg::*;
#(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] phase_i,
   input  logic          live_i,
   input  logic [IW-1:0] level_i,
   input  logic          force_i,
   input  pol_e          pol_i,
   output logic          blank_o
);
   logic window;
   logic disabled;

   always_comb begin
      window   = live_i && (phase_i != '0) && (phase_i <= level_i);
      disabled = force_i || !window;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blank_o <= 1'b1;
      else
         blank_o <= drive_level(disabled, pol_i);
   end

endmodule

// File: rtl/pwm_blank_mod.sv
module pwm_blank_mod
   import pwm_blank_pkg::*;
#(
   parameter int IW        = 4,
   parameter int PHASE_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] level_i,
   input  logic          pol_sel_i,
   input  logic          slot_start_i,
   input  logic          force_blank_i,
   output logic          blank_o
);
   generate
      if (IW < 2 || IW > 8) begin : g_bad_iw
         $error("pwm_blank_mod: IW must lie in 2..8");
      end
      if (PHASE_LEN < 1) begin : g_bad_len
         $error("pwm_blank_mod: PHASE_LEN must be at least 1");
      end
   endgenerate

   logic [IW-1:0] phase_w;
   logic [IW-1:0] level_w;
   logic          live_w;
   pol_e          pol_w;

   assign pol_w = pol_e'(pol_sel_i);

   phase_timer #(.IW(IW), .PHASE_LEN(PHASE_LEN)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (slot_start_i),
      .phase_o (phase_w),
      .live_o  (live_w)
   );

   level_latch #(.IW(IW)) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (slot_start_i),
      .level_i   (level_i),
      .level_o   (level_w)
   );

   blank_shaper #(.IW(IW)) u_shape (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_i (phase_w),
      .live_i  (live_w),
      .level_i (level_w),
      .force_i (force_blank_i),
      .pol_i   (pol_w),
      .blank_o (blank_o)
   );

endmodule

// File: rtl/pwm_blank_chk.sv
module pwm_blank_chk #(
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          slot_start_i,
   input logic          force_blank_i,
   input logic          pol_sel_i,
   input logic          blank_o,
   input logic [IW-1:0] phase_w,
   input logic [IW-1:0] level_w,
   input logic          live_w
);
   localparam logic [IW-1:0] TOP = {IW{1'b1}};

   assert_idle_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !live_w |=> (blank_o == ~$past(pol_sel_i)));

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start_i |=> (phase_w == '0) && live_w);

   assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_w == TOP) && !slot_start_i) |=> (phase_w == TOP));

   assert_lead_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_w == '0) |=> (blank_o == ~$past(pol_sel_i)));

   assert_nonzero_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start_i |=> (level_w != '0));

   assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_start_i |=> $stable(level_w));

   assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_blank_i |=> (blank_o == ~$past(pol_sel_i)));

endmodule

bind pwm_blank_mod pwm_blank_chk #(.IW(IW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .slot_start_i  (slot_start_i),
   .force_blank_i (force_blank_i),
   .pol_sel_i     (pol_sel_i),
   .blank_o       (blank_o),
   .phase_w       (phase_w),
   .level_w       (level_w),
   .live_w        (live_w)
);

// File: tb/sim_pwm_blank_mod.sv
module sim_pwm_blank_mod;
   localparam int IW = 4;
   localparam int PL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] level_i = '0;
   logic          pol_sel_i = 1'b0;
   logic          slot_start_i = 1'b0;
   logic          force_blank_i = 1'b0;
   logic          blank_o;

   int checks = 0;
   int errors = 0;

   // reference model state
   int   since = -1;
   int   k_ref = 1;
   logic exp_out = 1'b1;

   always #5 clk = ~clk;

   pwm_blank_mod #(.IW(IW), .PHASE_LEN(PL)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .level_i       (level_i),
      .pol_sel_i     (pol_sel_i),
      .slot_start_i  (slot_start_i),
      .force_blank_i (force_blank_i),
      .blank_o       (blank_o)
   );

   function automatic logic model_out(int s, int k, logic frc, logic pol);
      logic off;
      int   ph;
      off = 1'b1;
      if (!frc && s >= 0) begin
         ph = s / PL;
         if (ph > 15) ph = 15;
         if (ph >= 1 && ph <= k) off = 1'b0;
      end
      return pol ? ~off : off;
   endfunction

   task automatic check(string tag);
      checks++;
      if (blank_o !== exp_out) begin
         errors++;
         $display("FAIL %s: blank_o=%0b expected=%0b at %0t", tag, blank_o, exp_out, $time);
      end
   endtask

   // one clock: model updates at the edge, output compared at the falling edge
   task automatic step(string tag);
      @(posedge clk);
      if (!rst_n) begin
         since = -1; k_ref = 1; exp_out = 1'b1;
      end else begin
         exp_out = model_out(since, k_ref, force_blank_i, pol_sel_i);
         if (slot_start_i) begin
            since = 0;
            k_ref = (level_i == 0) ? 1 : int'(level_i);
         end else if (since >= 0 && since < 1000) begin
            since++;
         end
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic slot(logic [IW-1:0] lvl, string tag);
      level_i = lvl;
      slot_start_i = 1'b1;
      step(tag);
      slot_start_i = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      run(3, "R1");
      rst_n = 1'b1;
      run(10, "R1");              // no slot seen yet: held blank

      slot(4'd5, "R4");  run(70, "R4");
      slot(4'd15, "R3"); run(8, "R3");
      slot(4'd0, "R5");  run(70, "R5");
      slot(4'd15, "R6"); level_i = 4'd2; run(70, "R6");
      slot(4'd15, "R2"); run(150, "R2");   // saturated phase 15 stays enabled
      slot(4'd1, "R2");  run(20, "R2");    // restart mid-saturation

      slot(4'd12, "R7");
      run(20, "R7");
      force_blank_i = 1'b1; run(10, "R7");
      force_blank_i = 1'b0; run(40, "R7");

      pol_sel_i = 1'b1;
      slot(4'd8, "R8"); run(70, "R8");
      force_blank_i = 1'b1; run(5, "R8");
      force_blank_i = 1'b0;
      pol_sel_i = 1'b0; run(5, "R8");

      begin
         int period = 40;
         int cnt = 0;
         for (int c = 0; c < 4000; c++) begin
            level_i       = IW'($urandom_range(15, 0));
            force_blank_i = ($urandom_range(15, 0) == 0);
            if ($urandom_range(199, 0) == 0) pol_sel_i = ~pol_sel_i;
            cnt++;
            if (cnt >= period) begin
               cnt = 0;
               period = $urandom_range(100, 10);
               slot_start_i = 1'b1;
            end else begin
               slot_start_i = 1'b0;
            end
            step("R4");
         end
         slot_start_i = 1'b0;
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule